// File: doc/BRIEF.md
# Page-Mode Nibble-Pair Byte Fetcher

This block drives a 64K x 4-bit dynamic RAM through a strobe sequence that repeats every eight clock cycles. In each eight-cycle slot with work to do, it puts a row address on a shared address bus and lowers the active-low row strobe. It then presents two column addresses in turn and lowers the active-low column strobe once for each, while the row strobe stays low (page mode). The two 4-bit values returned are joined into one byte. That byte is delivered with a single-cycle valid pulse.

The requester supplies a 16-bit byte address together with a request strobe. Fetches begin only on the first phase of the eight-phase sequence. A request that arrives at any other time is held in a one-entry holding register until the next slot boundary. The phase counter runs freely from reset, so the slot grid is fixed. Slots that have no request keep both strobes inactive.

Top module: `nib_byte_fetch`

## Requirements
- R1: While reset is asserted and in the cycle after its release, both strobes are high, the valid output is low and the data output is zero.
- R2: A phase counter starts at 0 after reset and advances by one every clock, wrapping 7 to 0. In a busy slot the row strobe is low in phases 1 through 7, and the column strobe is low in phases 3, 4, 6 and 7. Both strobes are high in phase 0.
- R3: In a busy slot the address bus carries the row (request address bits 15:8) in phases 0-1. It carries the first column {addr[7:1],0} in phases 2-4 and the second column {addr[7:1],1} in phases 5-7. The bus does not change on a clock edge where either strobe falls.
- R4: The RAM data is sampled at the end of phase 4 and becomes output bits 3:0. It is sampled again at the end of phase 7 and becomes output bits 7:4.
- R5: The valid output is high for exactly one cycle, the phase 0 that follows a busy slot. The data output carries the fetched byte in that cycle and holds it until the next fetch completes.
- R6: A request sampled on the clock edge that begins phase 0 starts a slot at once. A request sampled on any other edge starts the slot at the next phase 0.
- R7: When more than one request is sampled before the same phase 0, only the most recent address is fetched.
- R8: A request sampled during a busy slot leaves that slot's strobes, address and data unchanged and is served in the following slot.
- R9: A slot with no request keeps both strobes high and raises no valid pulse.
- R10: Request address bit 0 has no effect on the fetched byte: byte addresses 2k and 2k+1 return the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per phase |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Fetch request strobe, sampled every clock |
| reqAddr | input | 16 | Byte address of the request |
| dramRasN | output | 1 | Active-low row strobe |
| dramCasN | output | 1 | Active-low column strobe |
| dramAddr | output | 8 | Multiplexed row/column address bus |
| dramData | input | 4 | Data returned by the RAM |
| byteValid | output | 1 | One-cycle pulse when a byte is ready |
| byteData | output | 8 | Assembled byte |

## Verification
A request sampled on an edge opens its slot on the first edge whose phase becomes 0, counting that edge itself. The strobes and the address bus change on the edge that begins each phase. The valid pulse and the byte arrive eight cycles after the slot opens, in the next phase 0. The bench keeps its own phase count, starting from reset release, and steps a reference model of slot, held and current addresses on every rising edge. It compares strobes, bus, valid and data at each falling edge against that model, so every result is checked in the exact cycle it is due. A bench RAM model returns data only from the second cycle of each column-strobe low period, so sampling a cycle early yields a wrong nibble.

// File: rtl/nbf_pkg.sv
`timescale 1ns/1ps
package nbf_pkg;

  localparam int PH_W = 3;

  // Phase numbers where the strobe schedule changes.
  localparam logic [PH_W-1:0] PH_RAS_FALL = 3'd1;
  localparam logic [PH_W-1:0] PH_COL0     = 3'd2;
  localparam logic [PH_W-1:0] PH_CAS0     = 3'd3;
  localparam logic [PH_W-1:0] PH_CAP0     = 3'd4;
  localparam logic [PH_W-1:0] PH_COL1     = 3'd5;
  localparam logic [PH_W-1:0] PH_CAS1     = 3'd6;
  localparam logic [PH_W-1:0] PH_CAP1     = 3'd7;

  typedef enum logic [1:0] {
    SEL_ROW  = 2'd0,
    SEL_COL0 = 2'd1,
    SEL_COL1 = 2'd2
  } addrSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     holdLd;    // park the incoming address
    logic     loadNew;   // slot opens with the incoming address
    logic     loadHeld;  // slot opens with the parked address
    addrSel_e sel;       // bus source for this phase
    logic     capLo;     // sample first nibble at end of this cycle
    logic     capHi;     // sample second nibble and publish byte
  } ctlStrb_t;

  function automatic logic rasLow(input logic [PH_W-1:0] ph);
    return ph >= PH_RAS_FALL;
  endfunction

  function automatic logic casLow(input logic [PH_W-1:0] ph);
    return (ph == PH_CAS0) || (ph == PH_CAP0) || (ph == PH_CAS1) || (ph == PH_CAP1);
  endfunction

  function automatic addrSel_e selFor(input logic [PH_W-1:0] ph);
    if (ph < PH_COL0)      return SEL_ROW;
    else if (ph < PH_COL1) return SEL_COL0;
    else                   return SEL_COL1;
  endfunction

endpackage

// File: rtl/nbf_ctrl.sv
`timescale 1ns/1ps
module nbf_ctrl
  import nbf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     rasN,
  output logic     casN,
  output ctlStrb_t ctl
);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] nxtPh;
  logic            busy;
  logic            busyNext;
  logic            pending;
  logic            slotStart;
  addrSel_e        selQ;
  logic            capLoQ;
  logic            capHiQ;

  always_comb begin
    nxtPh     = ph + 1'b1;
    slotStart = (nxtPh == '0) && (reqValid || pending);
    busyNext  = (nxtPh == '0) ? slotStart : busy;
  end

  // Strobes are registered from the phase about to begin so that they
  // switch cleanly on the edge that opens each phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph      <= '0;
      busy    <= 1'b0;
      pending <= 1'b0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      selQ    <= SEL_ROW;
      capLoQ  <= 1'b0;
      capHiQ  <= 1'b0;
    end else begin
      ph   <= nxtPh;
      busy <= busyNext;
      if (slotStart)     pending <= 1'b0;
      else if (reqValid) pending <= 1'b1;
      rasN   <= !(busyNext && rasLow(nxtPh));
      casN   <= !(busyNext && casLow(nxtPh));
      selQ   <= selFor(nxtPh);
      capLoQ <= busyNext && (nxtPh == PH_CAP0);
      capHiQ <= busyNext && (nxtPh == PH_CAP1);
    end
  end

  always_comb begin
    ctl.holdLd   = reqValid && !slotStart;
    ctl.loadNew  = slotStart && reqValid;
    ctl.loadHeld = slotStart && !reqValid;
    ctl.sel      = selQ;
    ctl.capLo    = capLoQ;
    ctl.capHi    = capHiQ;
  end

endmodule

// File: rtl/nbf_dpath.sv
`timescale 1ns/1ps
module nbf_dpath
  import nbf_pkg::*;
#(
  parameter  int ROW_W  = 8,
  parameter  int COL_W  = 8,
  parameter  int NIB_W  = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [NIB_W-1:0]    dramData,
  output logic [DA_W-1:0]     dramAddr,
  output logic                byteValid,
  output logic [2*NIB_W-1:0]  byteData
);

  // Bit 0 of the byte address never reaches the RAM: the nibble-select
  // bit of the column is generated from the phase instead.
  logic                unusedLsb;
  logic [ADDR_W-1:1]   holdAddr;
  logic [ADDR_W-1:1]   curAddr;
  logic [NIB_W-1:0]    nibLo;
  logic [ROW_W-1:0]    rowPart;
  logic [COL_W-1:1]    colBase;

  assign unusedLsb = reqAddr[0];
  assign rowPart   = curAddr[ADDR_W-1 -: ROW_W];
  assign colBase   = curAddr[COL_W-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr  <= '0;
      curAddr   <= '0;
      nibLo     <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      if (ctl.holdLd)   holdAddr <= reqAddr[ADDR_W-1:1];
      if (ctl.loadNew)  curAddr  <= reqAddr[ADDR_W-1:1];
      if (ctl.loadHeld) curAddr  <= holdAddr;
      if (ctl.capLo)    nibLo    <= dramData;
      byteValid <= ctl.capHi;
      if (ctl.capHi)    byteData <= {dramData, nibLo};
    end
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_COL0: dramAddr = DA_W'({colBase, 1'b0});
      SEL_COL1: dramAddr = DA_W'({colBase, 1'b1});
      default:  dramAddr = DA_W'(rowPart);
    endcase
  end

endmodule

// File: rtl/nib_byte_fetch.sv
`timescale 1ns/1ps
module nib_byte_fetch
  import nbf_pkg::*;
#(
  parameter  int ROW_W  = 8,
  parameter  int COL_W  = 8,
  parameter  int NIB_W  = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic [DA_W-1:0]   dramAddr,
  input  logic [NIB_W-1:0]  dramData,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData
);

  ctlStrb_t ctl;

  nbf_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rasN     (dramRasN),
    .casN     (dramCasN),
    .ctl      (ctl)
  );

  nbf_dpath #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .NIB_W (NIB_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .dramData  (dramData),
    .dramAddr  (dramAddr),
    .byteValid (byteValid),
    .byteData  (byteData)
  );

endmodule

// File: rtl/nbf_checker.sv
`timescale 1ns/1ps
module nbf_checker #(
  parameter int DA_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            dramRasN,
  input logic            dramCasN,
  input logic [DA_W-1:0] dramAddr,
  input logic            byteValid
);

  // R2: column strobe only inside a row strobe (page mode)
  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  // R2: the row strobe stays low at least one more cycle after falling
  a_r2_ras_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |=> !dramRasN);

  // R2: strobes precharged in the phase 0 carrying the valid pulse
  a_r2_precharge: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (dramRasN && dramCasN));

  // R3: bus steady on the edge where the row strobe falls
  a_r3_row_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> $stable(dramAddr));

  // R3: bus steady on the edge where the column strobe falls
  a_r3_col_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> $stable(dramAddr));

  // R5: valid lasts one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R4: a byte is published only right after a column access
  a_r4_valid_after_cas: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(!dramCasN));

endmodule

bind nib_byte_fetch nbf_checker #(.DA_W(DA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .dramRasN  (dramRasN),
  .dramCasN  (dramCasN),
  .dramAddr  (dramAddr),
  .byteValid (byteValid)
);

// File: tb/nib_byte_fetch_tb_top.sv
`timescale 1ns/1ps
module nib_byte_fetch_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [15:0] reqAddr;
  logic        dramRasN;
  logic        dramCasN;
  logic [7:0]  dramAddr;
  logic [3:0]  dramData;
  logic        byteValid;
  logic [7:0]  byteData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit live   = 0;
  bit done   = 0;
  string scen = "R9";

  always #2 clk = ~clk;

  nib_byte_fetch dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .dramRasN  (dramRasN),
    .dramCasN  (dramCasN),
    .dramAddr  (dramAddr),
    .dramData  (dramData),
    .byteValid (byteValid),
    .byteData  (byteData)
  );

  // ---------------- RAM model ----------------
  function automatic logic [3:0] nib(input logic [7:0] r, input logic [7:0] c);
    logic [7:0] t;
    t = (r * 8'd13) ^ (c * 8'd7) ^ (c >> 3);
    return t[3:0] ^ t[7:4] ^ {c[0], c[0], 1'b0, c[0]};
  endfunction

  logic [7:0] mRow = '0;
  logic [7:0] mCol = '0;
  int casAge = 0;

  always @(negedge dramRasN) mRow = dramAddr;
  always @(negedge dramCasN) mCol = dramAddr;
  always @(posedge clk) casAge <= (dramCasN === 1'b0) ? casAge + 1 : 0;

  assign dramData = (dramRasN === 1'b0 && dramCasN === 1'b0 && casAge >= 1)
                    ? nib(mRow, mCol) : 4'h0;

  // ---------------- reference model ----------------
  function automatic logic [7:0] byteOf(input logic [15:0] a);
    return {nib(a[15:8], {a[7:1], 1'b1}), nib(a[15:8], {a[7:1], 1'b0})};
  endfunction

  int         ph = 0;
  bit         mBusy = 0;
  bit         mPend = 0;
  logic [15:0] mHold = '0;
  logic [15:0] mAddr = '0;
  bit         expValid = 0;
  logic [7:0] expData = '0;

  always @(posedge clk) begin
    if (live) begin
      cyc = cyc + 1;
      ph  = cyc % 8;
      if (ph == 0) begin
        expValid = mBusy;
        if (mBusy) expData = byteOf(mAddr);
        if (reqValid || mPend) begin
          mBusy = 1;
          mAddr = reqValid ? reqAddr : mHold;
          mPend = 0;
        end else begin
          mBusy = 0;
        end
      end else begin
        expValid = 0;
        if (reqValid) begin
          mPend = 1;
          mHold = reqAddr;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (live && !done) begin
      logic eRas, eCas;
      logic [7:0] eBus;
      eRas = !(mBusy && ph >= 1);
      eCas = !(mBusy && (ph == 3 || ph == 4 || ph == 6 || ph == 7));
      chk(mBusy ? "R2" : "R9", "row strobe", 16'(dramRasN), 16'(eRas));
      chk(mBusy ? "R2" : "R9", "column strobe", 16'(dramCasN), 16'(eCas));
      if (mBusy) begin
        if (ph <= 1)      eBus = mAddr[15:8];
        else if (ph <= 4) eBus = {mAddr[7:1], 1'b0};
        else              eBus = {mAddr[7:1], 1'b1};
        chk("R3", "address bus", 16'(dramAddr), 16'(eBus));
      end
      chk("R5", "valid", 16'(byteValid), 16'(expValid));
      if (expValid) chk({"R4/", scen}, "byte", 16'(byteData), 16'(expData));
      else          chk("R5", "held byte", 16'(byteData), 16'(expData));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [15:0] a, input int p);
    @(negedge clk);
    while (cyc % 8 != p) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "row strobe in reset", 16'(dramRasN), 16'h1);
    chk("R1", "column strobe in reset", 16'(dramCasN), 16'h1);
    chk("R1", "valid in reset", 16'(byteValid), 16'h0);
    chk("R1", "byte in reset", 16'(byteData), 16'h0);
    rstN = 1'b1;
    live = 1;

    scen = "R9";
    repeat (24) @(negedge clk);

    // R6: requests at every phase offset, many addresses
    scen = "R6";
    for (int i = 0; i < 768; i++) begin
      issue(16'(i * 16'h0123 + i), i % 8);
      repeat (10) @(negedge clk);
    end

    // R7: two requests in one waiting window, latest wins
    scen = "R7";
    for (int k = 0; k < 8; k++) begin
      issue(16'(16'h1000 + k * 16'h0311), 1);
      issue(16'(16'hA0F0 - k * 16'h0107), 4);
      repeat (18) @(negedge clk);
    end

    // R8: request during a busy slot, then a held-high request stream
    scen = "R8";
    for (int k = 0; k < 8; k++) begin
      issue(16'(16'h5A00 + k * 16'h0203), 7);
      issue(16'(16'h3C3C + k * 16'h1111), 1 + (k % 6));
      repeat (20) @(negedge clk);
    end
    for (int k = 0; k < 40; k++) begin
      reqValid = 1'b1;
      reqAddr  = 16'(16'hC001 + k * 16'h0457);
      @(negedge clk);
    end
    reqValid = 1'b0;
    repeat (20) @(negedge clk);

    // R10: even and odd byte addresses of the same pair
    scen = "R10";
    for (int k = 0; k < 16; k++) begin
      issue(16'(k * 16'h0F12) & 16'hFFFE, 7);
      repeat (12) @(negedge clk);
      issue(16'(k * 16'h0F12) | 16'h0001, 7);
      repeat (12) @(negedge clk);
    end

    scen = "R9";
    repeat (24) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule